// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Flagged Character Queue

This block turns a serial line into parallel characters. It works from a sample tick that runs at sixteen times the bit rate. A falling edge on the line starts a start-bit check. The check samples the line near the middle of the start bit, and a start bit that has gone high again by then is rejected. Once a start bit is accepted, the data bits (least significant first), an optional parity bit and one stop bit are each sampled at their centres. Every finished character goes into a three-entry queue together with three flags: parity error, framing error and break.

The host takes characters from the queue through a valid/ready stream port. `rd_valid` is high while the queue holds at least one character, and `rd_data`/flags show the oldest entry. A character leaves the queue only in a cycle where both `rd_valid` and `rd_ready` are high. The host may hold `rd_ready` low for as long as it likes. The head entry then stays unchanged, and incoming characters back up into the queue, then into one holding slot, and after that they overrun. The status outputs have no side effects when read.

The error status can show only the head entry, or it can show a sticky OR of every entry that has reached the head since the last error-clear command. An overrun flag and optional automatic flow control through `rts_n` complete the block. Single-cycle command pulses enable the receiver, disable it, reset it, and clear the error status.

Top module: `serial_rx_queue`

## Requirements
- R1: After a falling edge seen on a sample tick, the line is sampled again 7 ticks later. If it is high at that point, no character is produced and the hunt for a start edge begins again.
- R2: The data bits are sampled 16 ticks apart, least significant bit first. The character length is 5 + `cfg_len` bits (`cfg_len` 0..3 gives 5..8 bits). The unused upper bits of `rd_data` read as zero.
- R3: With `cfg_par_en`=1, a parity bit follows the data. The expected parity bit makes the total count of ones even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1. A mismatch sets the entry's `rd_pe`.
- R4: A low stop bit sets the entry's `rd_fe`. If the frame held at least one 1 and the line is still low 8 ticks after the stop sample, that tick is taken as a new start edge, with no high period needed first.
- R5: A frame that is low in every data bit, the parity bit and the stop bit produces one entry with data 0, `rd_brk`=1, `rd_fe`=1 and `rd_pe`=0. No further start is accepted until the line has been high for 8 consecutive ticks.
- R6: The queue holds 3 entries in arrival order. `rd_valid` is 1 while at least one entry is held, and `st_full` is 1 while all 3 are held. A pop happens only when `rd_valid` and `rd_ready` are both high. The head output is stable while it is not popped.
- R7: When `cfg_block`=0, `st_pe`/`st_fe`/`st_brk` equal the head entry's flags, and they are 0 when the queue is empty.
- R8: When `cfg_block`=1, each status flag is the OR of that flag over every entry that was at the head since the last `cmd_err_clr`, including the current head. The flags stay set after those entries are popped.
- R9: A character that finishes while the queue is full waits in a holding slot and enters the queue when an entry is popped. If a new start bit is accepted while the slot is occupied and no pop happens in that cycle, the waiting character is discarded, the queue is left unchanged and `st_ovr` is set. `cmd_err_clr` clears `st_ovr`.
- R10: With `cfg_auto_rts`=1, `rts_n` goes to 1 on a start bit accepted while the queue is full, and returns to 0 in the cycle after the queue is no longer full. With `cfg_auto_rts`=0, `rts_n` stays 0.
- R11: After `cmd_disable` (and after reset), no new start bit is accepted, but entries already held can still be read. `cmd_enable` re-arms the receiver.
- R12: `cmd_reset` empties the queue and the holding slot, clears all status, sets `rts_n` to 0 and leaves the receiver disabled.
- R13: After `rst_n` is deasserted: `rd_valid`=0, `st_full`=0, all status flags 0, `rts_n`=0, receiver disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sample tick, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Character length code, length = 5 + value |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_block | input | 1 | 1 = accumulated error status, 0 = head-only |
| cfg_auto_rts | input | 1 | Enable automatic RTS negation |
| cmd_enable | input | 1 | Pulse: enable receiver |
| cmd_disable | input | 1 | Pulse: disable receiver |
| cmd_reset | input | 1 | Pulse: reset receiver, queue and status |
| cmd_err_clr | input | 1 | Pulse: clear accumulated errors and overrun |
| rd_valid | output | 1 | Head entry available |
| rd_ready | input | 1 | Host accepts head entry |
| rd_data | output | 8 | Head character, unused bits zero |
| rd_pe | output | 1 | Head parity error flag |
| rd_fe | output | 1 | Head framing error flag |
| rd_brk | output | 1 | Head break flag |
| st_full | output | 1 | All queue entries occupied |
| st_pe | output | 1 | Parity error status |
| st_fe | output | 1 | Framing error status |
| st_brk | output | 1 | Break status |
| st_ovr | output | 1 | Overrun status |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
All 256 eight-bit values are received without parity. This separates bit order, bit-centre timing and any stuck or swapped data lines. Sixteen values are then sent for each of the twelve length and parity combinations, which exposes masking of the upper bits and parity polarity. Frames with a wrong parity bit, a start glitch shorter than half a bit, a low stop bit followed at once by another frame, and a long break each test one branch of the framing logic. A burst of four and then five characters without reads separates correct holding from overrun loss, and the same burst checks when `rts_n` rises and falls. The same pair of bad and clean characters is read in both status modes, which shows the difference between head-only and accumulated flags.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
  localparam int SQR_DW = 8;

  typedef struct packed {
    logic [SQR_DW-1:0] data;
    logic              pe;
    logic              fe;
    logic              brk;
  } sqr_entry_t;

  typedef enum logic [2:0] {
    S_HUNT, S_START, S_DATA, S_PAR, S_STOP, S_BRKW, S_RESYNC
  } sqr_state_t;
endpackage

// File: rtl/sqr_sampler.sv
module sqr_sampler
  import sqr_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic       rxd,
  input  logic       en,
  input  logic [1:0] cfg_len,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       start_ok,
  output logic       done,
  output sqr_entry_t ent
);
  localparam int CW      = $clog2(OS);
  localparam int HALF    = OS / 2;
  localparam int IW      = $clog2(SQR_DW);
  localparam int MIN_LEN = SQR_DW - 3;

  sqr_state_t      state;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   idx;
  logic [IW-1:0]   last_idx;
  logic [SQR_DW-1:0] shreg;
  logic            prev, any1, par_acc, pbit;

  assign last_idx = IW'(MIN_LEN - 1) + IW'(cfg_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_HUNT; cnt <= '0; idx <= '0; shreg <= '0;
      prev <= 1'b1; any1 <= 1'b0; par_acc <= 1'b0; pbit <= 1'b0;
      start_ok <= 1'b0; done <= 1'b0; ent <= '0;
    end else begin
      start_ok <= 1'b0;
      done     <= 1'b0;
      if (clr) begin
        state <= S_HUNT; cnt <= '0; prev <= 1'b1;
      end else if (tick) begin
        prev <= rxd;
        unique case (state)
          S_HUNT: if (en && prev && !rxd) begin
            state <= S_START; cnt <= '0;
          end
          S_START: if (cnt == CW'(HALF - 2)) begin
            if (!rxd) begin
              state <= S_DATA; cnt <= '0; idx <= '0; shreg <= '0;
              any1 <= 1'b0; par_acc <= 1'b0; pbit <= 1'b0;
              start_ok <= 1'b1;
            end else begin
              state <= S_HUNT;
            end
          end else cnt <= cnt + 1'b1;
          S_DATA: if (cnt == CW'(OS - 1)) begin
            cnt <= '0;
            shreg[idx] <= rxd;
            any1 <= any1 | rxd;
            par_acc <= par_acc ^ rxd;
            if (idx == last_idx) state <= par_en ? S_PAR : S_STOP;
            else idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
          S_PAR: if (cnt == CW'(OS - 1)) begin
            cnt <= '0; pbit <= rxd; any1 <= any1 | rxd; state <= S_STOP;
          end else cnt <= cnt + 1'b1;
          S_STOP: if (cnt == CW'(OS - 1)) begin
            cnt       <= '0;
            done      <= 1'b1;
            ent.data  <= shreg;
            ent.fe    <= !rxd;
            ent.brk   <= !rxd && !any1;
            ent.pe    <= par_en && (rxd || any1) && (par_acc ^ pbit ^ par_odd);
            if (rxd)       state <= S_HUNT;
            else if (any1) state <= S_RESYNC;
            else           state <= S_BRKW;
          end else cnt <= cnt + 1'b1;
          S_BRKW: if (rxd) begin
            if (cnt == CW'(HALF - 1)) state <= S_HUNT;
            else cnt <= cnt + 1'b1;
          end else cnt <= '0;
          S_RESYNC: if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            state <= (!rxd && en) ? S_START : S_HUNT;
          end else cnt <= cnt + 1'b1;
          default: state <= S_HUNT;
        endcase
      end
    end
  end

  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> $past(!rxd && tick));
  // R5
  brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ent.brk) |-> (ent.data == '0 && ent.fe && !ent.pe));
  // R2
  done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tick));
endmodule

// File: rtl/sqr_fifo.sv
module sqr_fifo
  import sqr_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       push,
  input  sqr_entry_t din,
  input  logic       pop,
  output sqr_entry_t dout,
  output logic       empty,
  output logic       full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  sqr_entry_t     mem [DEPTH];
  logic [PW-1:0]  wp, rp;
  logic [NW-1:0]  count;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == NW'(DEPTH));
  assign dout  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) begin
        mem[wp] <= din;
        wp <= nxt(wp);
      end
      if (pop) rp <= nxt(rp);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  // R6
  fifo_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |-> (!full || pop));
  // R6
  fifo_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R6
  fifo_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= NW'(DEPTH));
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import sqr_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int OS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_block,
  input  logic              cfg_auto_rts,
  input  logic              cmd_enable,
  input  logic              cmd_disable,
  input  logic              cmd_reset,
  input  logic              cmd_err_clr,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [SQR_DW-1:0] rd_data,
  output logic              rd_pe,
  output logic              rd_fe,
  output logic              rd_brk,
  output logic              st_full,
  output logic              st_pe,
  output logic              st_fe,
  output logic              st_brk,
  output logic              st_ovr,
  output logic              rts_n
);
  logic       enabled, start_ok, done, f_empty, f_full, pop, push;
  sqr_entry_t s_ent, head, hold_e, f_in;
  logic       hold_v, acc_pe, acc_fe, acc_brk;

  sqr_sampler #(.OS(OS)) u_samp (
    .clk(clk), .rst_n(rst_n), .clr(cmd_reset), .tick(tick16), .rxd(rxd),
    .en(enabled), .cfg_len(cfg_len), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .start_ok(start_ok), .done(done), .ent(s_ent)
  );

  sqr_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(cmd_reset), .push(push), .din(f_in),
    .pop(pop), .dout(head), .empty(f_empty), .full(f_full)
  );

  assign rd_valid = !f_empty;
  assign pop      = rd_valid && rd_ready;
  assign rd_data  = head.data;
  assign rd_pe    = head.pe;
  assign rd_fe    = head.fe;
  assign rd_brk   = head.brk;
  assign st_full  = f_full;

  always_comb begin
    if (hold_v) begin
      push = pop;
      f_in = hold_e;
    end else begin
      push = done && (!f_full || pop);
      f_in = s_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0; hold_v <= 1'b0; hold_e <= '0; st_ovr <= 1'b0;
      acc_pe <= 1'b0; acc_fe <= 1'b0; acc_brk <= 1'b0; rts_n <= 1'b0;
    end else if (cmd_reset) begin
      enabled <= 1'b0; hold_v <= 1'b0; st_ovr <= 1'b0;
      acc_pe <= 1'b0; acc_fe <= 1'b0; acc_brk <= 1'b0; rts_n <= 1'b0;
    end else begin
      if (cmd_enable)       enabled <= 1'b1;
      else if (cmd_disable) enabled <= 1'b0;

      if (hold_v && pop) hold_v <= 1'b0;
      else if (hold_v && start_ok) hold_v <= 1'b0;
      else if (!hold_v && done && f_full && !pop) begin
        hold_v <= 1'b1;
        hold_e <= s_ent;
      end

      if (cmd_err_clr) st_ovr <= 1'b0;
      else if (hold_v && start_ok && !pop) st_ovr <= 1'b1;

      if (cmd_err_clr) begin
        acc_pe <= 1'b0; acc_fe <= 1'b0; acc_brk <= 1'b0;
      end else if (rd_valid) begin
        acc_pe  <= acc_pe  | head.pe;
        acc_fe  <= acc_fe  | head.fe;
        acc_brk <= acc_brk | head.brk;
      end

      if (!cfg_auto_rts)          rts_n <= 1'b0;
      else if (start_ok && f_full) rts_n <= 1'b1;
      else if (!f_full)           rts_n <= 1'b0;
    end
  end

  always_comb begin
    st_pe  = rd_valid && head.pe;
    st_fe  = rd_valid && head.fe;
    st_brk = rd_valid && head.brk;
    if (cfg_block) begin
      st_pe  = st_pe  | acc_pe;
      st_fe  = st_fe  | acc_fe;
      st_brk = st_brk | acc_brk;
    end
  end

  // R9
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ovr) |-> $past(start_ok && hold_v));
  // R9
  hold_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v |-> f_full);
  // R10
  rts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_n) |-> $past(f_full && cfg_auto_rts));
  // R6
  head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_valid && !rd_ready && !cmd_reset)) |-> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/tb_serial_rx_queue.sv
module tb_serial_rx_queue;
  localparam int OS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b1, rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_block = 0, cfg_auto_rts = 0;
  logic cmd_enable = 0, cmd_disable = 0, cmd_reset = 0, cmd_err_clr = 0;
  logic rd_ready = 0;
  logic rd_valid, rd_pe, rd_fe, rd_brk, st_full, st_pe, st_fe, st_brk, st_ovr, rts_n;
  logic [7:0] rd_data;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  serial_rx_queue dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_block(cfg_block),
    .cfg_auto_rts(cfg_auto_rts), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .cmd_reset(cmd_reset), .cmd_err_clr(cmd_err_clr), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_pe(rd_pe), .rd_fe(rd_fe),
    .rd_brk(rd_brk), .st_full(st_full), .st_pe(st_pe), .st_fe(st_fe),
    .st_brk(st_brk), .st_ovr(st_ovr), .rts_n(rts_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic bitout(input logic v);
    rxd = v;
    repeat (OS) @(posedge clk);
    #1;
  endtask

  // par: 0 none, 1 even, 2 odd
  task automatic send(input logic [7:0] d, input int len, input int par,
                      input bit flip, input logic stopv, input int idle);
    logic p;
    @(posedge clk); #1;
    bitout(1'b0);
    for (int i = 0; i < len; i++) bitout(d[i]);
    if (par != 0) begin
      p = 1'b0;
      for (int i = 0; i < len; i++) p ^= d[i];
      if (par == 2) p = ~p;
      bitout(p ^ flip);
    end
    bitout(stopv);
    for (int i = 0; i < idle; i++) bitout(1'b1);
  endtask

  task automatic take(input string req, input logic [7:0] ed, input bit epe,
                      input bit efe, input bit ebrk);
    @(negedge clk);
    chk(rd_valid == 1'b1, req, rd_valid, 1);
    chk(rd_data == ed, req, rd_data, ed);
    chk({rd_pe, rd_fe, rd_brk} == {epe, efe, ebrk}, req, {rd_pe, rd_fe, rd_brk},
        {epe, efe, ebrk});
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] m;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(!rd_valid && !st_full, "R13 empty", {rd_valid, st_full}, 0);
    chk({st_pe, st_fe, st_brk, st_ovr, rts_n} == 0, "R13 status", {st_pe, st_fe, st_brk, st_ovr, rts_n}, 0);
    // R13/R11 disabled after reset: character ignored
    send(8'h5A, 8, 0, 0, 1, 2);
    @(negedge clk);
    chk(!rd_valid, "R11 disabled after reset", rd_valid, 0);
    pulse(cmd_enable);

    // R2 all 8-bit values, no parity
    for (int v = 0; v < 256; v++) begin
      send(8'(v), 8, 0, 0, 1, 1);
      take("R2 sweep8", 8'(v), 0, 0, 0);
    end
    // R2/R3 length and parity combinations
    for (int l = 0; l < 4; l++) begin
      for (int p = 0; p < 3; p++) begin
        cfg_len = 2'(l); cfg_par_en = (p != 0); cfg_par_odd = (p == 2);
        for (int k = 0; k < 16; k++) begin
          m = 8'((k * 37 + l * 11 + p * 5 + 3) & 8'hFF);
          send(m, 5 + l, p, 0, 1, 1);
          take("R2 R3 len/par", m & 8'((1 << (5 + l)) - 1), 0, 0, 0);
        end
      end
    end

    // R3 wrong parity, R7 head-only status
    cfg_len = 2'd3; cfg_par_en = 1; cfg_par_odd = 0; cfg_block = 0;
    send(8'h0F, 8, 1, 1, 1, 1);
    send(8'h21, 8, 1, 0, 1, 1);
    @(negedge clk);
    chk(st_pe == 1'b1, "R7 head pe", st_pe, 1);
    take("R3 parity error", 8'h0F, 1, 0, 0);
    @(negedge clk);
    chk(st_pe == 1'b0, "R7 clean head", st_pe, 0);
    take("R3 odd/even ok", 8'h21, 0, 0, 0);
    chk({st_pe, st_fe, st_brk} == 0, "R7 empty", {st_pe, st_fe, st_brk}, 0);
    // R3 odd parity error
    cfg_par_odd = 1;
    send(8'h33, 8, 2, 1, 1, 1);
    take("R3 odd error", 8'h33, 1, 0, 0);

    // R8 block mode
    cfg_block = 1; cfg_par_odd = 0;
    send(8'h44, 8, 1, 1, 1, 1);
    send(8'h45, 8, 1, 0, 1, 1);
    take("R8 first", 8'h44, 1, 0, 0);
    @(negedge clk);
    chk(st_pe == 1'b1, "R8 sticky after pop", st_pe, 1);
    take("R8 second", 8'h45, 0, 0, 0);
    @(negedge clk);
    chk(st_pe == 1'b1, "R8 sticky empty", st_pe, 1);
    pulse(cmd_err_clr);
    @(negedge clk);
    chk(st_pe == 1'b0, "R8 err clear", st_pe, 0);
    cfg_block = 0; cfg_par_en = 0;

    // R1 start glitch
    @(posedge clk); #1 rxd = 1'b0;
    repeat (5) @(posedge clk);
    #1 rxd = 1'b1;
    repeat (OS * 14) @(posedge clk);
    @(negedge clk);
    chk(!rd_valid, "R1 glitch rejected", rd_valid, 0);
    send(8'h3C, 8, 0, 0, 1, 1);
    take("R1 after glitch", 8'h3C, 0, 0, 0);

    // R4 framing error then immediate resync
    send(8'hA5, 8, 0, 0, 0, 0);
    send(8'h5A, 8, 0, 0, 1, 2);
    take("R4 framing", 8'hA5, 0, 1, 0);
    take("R4 resync", 8'h5A, 0, 0, 0);
    @(negedge clk);
    chk(!rd_valid, "R4 no extra", rd_valid, 0);

    // R5 break: long low, one entry
    @(posedge clk); #1 rxd = 1'b0;
    repeat (OS * 30) @(posedge clk);
    #1 rxd = 1'b1;
    repeat (OS * 2) @(posedge clk);
    @(negedge clk);
    chk(st_brk == 1'b1, "R5 brk status", st_brk, 1);
    take("R5 break", 8'h00, 0, 1, 1);
    @(negedge clk);
    chk(!rd_valid, "R5 single entry", rd_valid, 0);
    send(8'h11, 8, 0, 0, 1, 1);
    take("R5 after break", 8'h11, 0, 0, 0);

    // R6 R9 R10 full, hold and auto RTS
    cfg_auto_rts = 1;
    send(8'h01, 8, 0, 0, 1, 1);
    send(8'h02, 8, 0, 0, 1, 1);
    send(8'h03, 8, 0, 0, 1, 1);
    @(negedge clk);
    chk(st_full && !rts_n, "R6 full", {st_full, rts_n}, 2);
    repeat (5) @(negedge clk);
    chk(rd_data == 8'h01, "R6 stable head", rd_data, 1);
    send(8'h04, 8, 0, 0, 1, 1);
    @(negedge clk);
    chk(rts_n == 1'b1, "R10 negated", rts_n, 1);
    chk(!st_ovr, "R9 no overrun yet", st_ovr, 0);
    take("R9 order1", 8'h01, 0, 0, 0);
    @(negedge clk);
    chk(st_full && rts_n, "R9 hold refills", {st_full, rts_n}, 3);
    take("R6 order2", 8'h02, 0, 0, 0);
    @(negedge clk);
    chk(rts_n == 1'b0, "R10 reasserted", rts_n, 0);
    take("R6 order3", 8'h03, 0, 0, 0);
    take("R9 held char", 8'h04, 0, 0, 0);

    // R9 overrun
    send(8'h05, 8, 0, 0, 1, 1);
    send(8'h06, 8, 0, 0, 1, 1);
    send(8'h07, 8, 0, 0, 1, 1);
    send(8'h08, 8, 0, 0, 1, 1);
    send(8'h09, 8, 0, 0, 1, 1);
    @(negedge clk);
    chk(st_ovr == 1'b1, "R9 overrun", st_ovr, 1);
    take("R9 o1", 8'h05, 0, 0, 0);
    take("R9 o2", 8'h06, 0, 0, 0);
    take("R9 o3", 8'h07, 0, 0, 0);
    take("R9 survivor", 8'h09, 0, 0, 0);
    pulse(cmd_err_clr);
    @(negedge clk);
    chk(!st_ovr && !rts_n, "R9 clear", {st_ovr, rts_n}, 0);
    cfg_auto_rts = 0;

    // R11 disable keeps queue readable
    send(8'h66, 8, 0, 0, 1, 1);
    pulse(cmd_disable);
    send(8'h77, 8, 0, 0, 1, 1);
    take("R11 readable", 8'h66, 0, 0, 0);
    @(negedge clk);
    chk(!rd_valid, "R11 ignored", rd_valid, 0);
    pulse(cmd_enable);

    // R12 reset command
    send(8'h12, 8, 0, 0, 1, 1);
    send(8'h34, 8, 1, 0, 0, 2);
    pulse(cmd_reset);
    @(negedge clk);
    chk(!rd_valid && !st_fe && !rts_n, "R12 cleared", {rd_valid, st_fe, rts_n}, 0);
    send(8'h56, 8, 0, 0, 1, 1);
    @(negedge clk);
    chk(!rd_valid, "R12 left disabled", rd_valid, 0);
    pulse(cmd_enable);
    send(8'h78, 8, 0, 0, 1, 1);
    take("R12 re-enabled", 8'h78, 0, 0, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule